// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance Controller

This block keeps the enable and request flags for three interrupt sources: an 8-bit timer that wraps, a base timer that wraps, and a group of digital input pins watched for a falling edge. The CPU sees the flags as two 4-bit system registers, which it reads and writes through one small register port. The block decides when an interrupt is accepted. It then tells the CPU to push the program counter and carry with a one-cycle pulse. A second one-cycle pulse follows, and it carries the vector code of the winning source.

The CPU reports every finished instruction with a retire strobe. With that strobe it raises a second flag when the instruction wrote the enable register. After such an instruction, acceptance waits until two more instructions have retired, and it is abandoned if the enable and request flags no longer overlap at either of those retirements. Acceptance clears all enable bits together, so an interrupt handler has to enable flags again before another interrupt can nest inside it. Two wake outputs let a halted or stopped CPU restart when a request is present.

Top module: `intr_accept_ctrl`

## Requirements
- R1: After reset both system registers read 0 and the push_pc, vec_load, vec_sel and both wake outputs are 0.
- R2: reg_sel=0 addresses the enable register and reg_sel=1 the request register. In both registers bit 2 is the first timer, bit 1 the base timer and bit 0 the port. Bit 3 always reads 0, and writes to it are dropped. A write takes effect at the next clock edge, and reg_rdata shows the addressed register without delay.
- R3: A tmr0_wrap pulse sets request bit 2 at the next edge, and a base_wrap pulse sets request bit 1. A request bit stays set until software writes 0 to it. A hardware set in the same cycle as a software write of 0 leaves the bit at 1.
- R4: Once all port_pins are high, the first pin that goes low sets request bit 0 at the next edge. No further port request is made until every pin has been high again.
- R5: An interrupt is accepted only when some bit is 1 in both registers. In the idle state, a retire strobe without enable_wr while such a bit exists causes push_pc to be 1 in the following cycle. With no such bit, a retire strobe causes nothing.
- R6: The active bit with the highest priority wins: bit 2 first, then bit 1, then bit 0. The vector codes are 3'b001 for the first timer, 3'b010 for the base timer and 3'b011 for the port.
- R7: push_pc is high for exactly one cycle. vec_load is high for exactly the next cycle, with vec_sel carrying the winning code. At all other times vec_sel is 0.
- R8: Acceptance clears all enable bits at the edge that ends the push_pc cycle. The request bits are left unchanged.
- R9: When a retire strobe comes with enable_wr (instruction N), acceptance waits for two more retire strobes (I1, I2). push_pc rises in the cycle after the I2 retirement, provided an enabled request is still present at both retirements.
- R10: If the enable or request bits written at or before the I1 or I2 retirement leave no bit set in both registers, the pending acceptance is dropped and no push_pc follows.
- R11: wake_halt is 1 whenever any request bit is set. wake_stop is 1 only while the port request bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | System register write strobe |
| reg_sel | input | 1 | 0 selects the enable register, 1 selects the request register |
| reg_wdata | input | 4 | Write data |
| reg_rdata | output | 4 | Read data of the addressed register |
| retire | input | 1 | One CPU instruction retires in this cycle |
| enable_wr | input | 1 | The retiring instruction wrote the enable register |
| tmr0_wrap | input | 1 | First timer wrapped from $FF to $00 |
| base_wrap | input | 1 | Base timer wrapped from $FF to $00 |
| port_pins | input | PORT_W | Digital input pins watched for a falling edge |
| push_pc | output | 1 | Push the program counter and carry this cycle |
| vec_load | output | 1 | Load the vector this cycle |
| vec_sel | output | 3 | Vector code of the winning source |
| wake_halt | output | 1 | Wake request from the halt state |
| wake_stop | output | 1 | Wake request from the stop state |

## Verification
Two things can happen in the same cycle. A timer wrap pulse can arrive while software writes 0 to the request register. In another case, an instruction's register write lands in the same cycle as its own retire strobe, while the sequencer decides whether to keep waiting. The bench drives both of these in one cycle. It reads back the request register to confirm the hardware set won. It also watches push_pc to show that a clear written by I1 or I2 drops the pending acceptance, and that an unchanged pair of flags leads to a push exactly one cycle after I2.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int NSRC  = 3;
    localparam int REG_W = 4;
    localparam int VEC_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT1,
        ST_WAIT2,
        ST_STACK,
        ST_VECTOR
    } seq_state_t;
endpackage

// File: rtl/intc_flags.sv
module intc_flags
    import intc_pkg::*;
#(
    parameter int PORT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              tmr0_wrap,
    input  logic              base_wrap,
    input  logic [PORT_W-1:0] pins,
    input  logic              clr_ie,
    output logic [NSRC-1:0]   ie_q,
    output logic [NSRC-1:0]   irq_q,
    output logic [NSRC-1:0]   ie_nxt,
    output logic [NSRC-1:0]   irq_nxt
);
    logic armed_q;
    logic all_high;
    logic port_evt;
    logic [NSRC-1:0] hw_set;
    logic unused_hi;

    assign unused_hi = ^wr_data[REG_W-1:NSRC];
    assign all_high  = &pins;
    assign port_evt  = armed_q && !all_high;
    assign hw_set    = {tmr0_wrap, base_wrap, port_evt};

    always_comb begin
        ie_nxt = ie_q;
        if (wr_en && !wr_sel) ie_nxt = wr_data[NSRC-1:0];
        if (clr_ie) ie_nxt = '0;
    end

    always_comb begin
        irq_nxt = irq_q;
        if (wr_en && wr_sel) irq_nxt = wr_data[NSRC-1:0];
        irq_nxt = irq_nxt | hw_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q    <= '0;
            irq_q   <= '0;
            armed_q <= 1'b0;
        end else begin
            ie_q    <= ie_nxt;
            irq_q   <= irq_nxt;
            if (all_high)      armed_q <= 1'b1;
            else if (port_evt) armed_q <= 1'b0;
        end
    end
endmodule

// File: rtl/intc_prio.sv
module intc_prio
    import intc_pkg::*;
(
    input  logic [NSRC-1:0]  active,
    output logic [VEC_W-1:0] code
);
    always_comb begin
        code = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (active[i]) code = VEC_W'(NSRC - i);
        end
    end
endmodule

// File: rtl/intc_seq.sv
module intc_seq
    import intc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             retire,
    input  logic             enable_wr,
    input  logic             pending,
    input  logic [VEC_W-1:0] win_code,
    output logic             push_pc,
    output logic             vec_load,
    output logic [VEC_W-1:0] vec_sel,
    output logic             clr_ie
);
    seq_state_t state_q, state_d;
    logic [VEC_W-1:0] win_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (retire) begin
                    if (enable_wr)    state_d = ST_WAIT1;
                    else if (pending) state_d = ST_STACK;
                end
            end
            ST_WAIT1:  if (retire) state_d = pending ? ST_WAIT2 : ST_IDLE;
            ST_WAIT2:  if (retire) state_d = pending ? ST_STACK : ST_IDLE;
            ST_STACK:  state_d = ST_VECTOR;
            ST_VECTOR: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            win_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_STACK && state_q != ST_STACK) win_q <= win_code;
        end
    end

    always_comb begin
        push_pc  = 1'b0;
        vec_load = 1'b0;
        vec_sel  = '0;
        clr_ie   = 1'b0;
        unique case (state_q)
            ST_STACK: begin
                push_pc = 1'b1;
                clr_ie  = 1'b1;
            end
            ST_VECTOR: begin
                vec_load = 1'b1;
                vec_sel  = win_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/intr_accept_ctrl.sv
module intr_accept_ctrl
    import intc_pkg::*;
#(
    parameter int PORT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_sel,
    input  logic [3:0]        reg_wdata,
    output logic [3:0]        reg_rdata,
    input  logic              retire,
    input  logic              enable_wr,
    input  logic              tmr0_wrap,
    input  logic              base_wrap,
    input  logic [PORT_W-1:0] port_pins,
    output logic              push_pc,
    output logic              vec_load,
    output logic [2:0]        vec_sel,
    output logic              wake_halt,
    output logic              wake_stop
);
    logic [NSRC-1:0]  ie_q, irq_q, ie_nxt, irq_nxt;
    logic [VEC_W-1:0] win_code;
    logic             clr_ie;
    logic             pending;

    intc_flags #(.PORT_W(PORT_W)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_we),
        .wr_sel    (reg_sel),
        .wr_data   (reg_wdata),
        .tmr0_wrap (tmr0_wrap),
        .base_wrap (base_wrap),
        .pins      (port_pins),
        .clr_ie    (clr_ie),
        .ie_q      (ie_q),
        .irq_q     (irq_q),
        .ie_nxt    (ie_nxt),
        .irq_nxt   (irq_nxt)
    );

    assign pending = |(ie_nxt & irq_nxt);

    intc_prio u_prio (
        .active (ie_nxt & irq_nxt),
        .code   (win_code)
    );

    intc_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .retire    (retire),
        .enable_wr (enable_wr),
        .pending   (pending),
        .win_code  (win_code),
        .push_pc   (push_pc),
        .vec_load  (vec_load),
        .vec_sel   (vec_sel),
        .clr_ie    (clr_ie)
    );

    assign reg_rdata = reg_sel ? {1'b0, irq_q} : {1'b0, ie_q};
    assign wake_halt = |irq_q;
    assign wake_stop = irq_q[0];
endmodule

// File: rtl/intc_accept_chk.sv
module intc_accept_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       retire,
    input logic       tmr0_wrap,
    input logic       base_wrap,
    input logic       push_pc,
    input logic       vec_load,
    input logic [2:0] vec_sel,
    input logic       wake_halt,
    input logic       wake_stop,
    input logic [2:0] ie_q,
    input logic [2:0] irq_q
);
    assert_tmr0_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tmr0_wrap |=> irq_q[2]);
    assert_base_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        base_wrap |=> irq_q[1]);
    assert_push_on_retire_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(push_pc) |-> $past(retire));
    assert_vec_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_load |-> (vec_sel == 3'd1 || vec_sel == 3'd2 || vec_sel == 3'd3));
    assert_push_then_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push_pc |=> (vec_load && !push_pc));
    assert_load_after_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vec_load |-> $past(push_pc));
    assert_sel_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_load |-> (vec_sel == 3'd0));
    assert_ie_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vec_load |-> (ie_q == 3'd0));
    assert_wake_order_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wake_stop |-> wake_halt);
endmodule

bind intr_accept_ctrl intc_accept_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .retire    (retire),
    .tmr0_wrap (tmr0_wrap),
    .base_wrap (base_wrap),
    .push_pc   (push_pc),
    .vec_load  (vec_load),
    .vec_sel   (vec_sel),
    .wake_halt (wake_halt),
    .wake_stop (wake_stop),
    .ie_q      (ie_q),
    .irq_q     (irq_q)
);

// File: tb/test_intr_accept_ctrl.sv
`timescale 1ns/1ps
module test_intr_accept_ctrl;
    localparam int PW = 4;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0, reg_sel = 1'b0;
    logic [3:0] reg_wdata = '0;
    logic [3:0] reg_rdata;
    logic retire = 1'b0, enable_wr = 1'b0;
    logic tmr0_wrap = 1'b0, base_wrap = 1'b0;
    logic [PW-1:0] port_pins = '1;
    logic push_pc, vec_load, wake_halt, wake_stop;
    logic [2:0] vec_sel;
    int errors = 0, checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    intr_accept_ctrl #(.PORT_W(PW)) i_intr_accept_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .retire(retire),
        .enable_wr(enable_wr), .tmr0_wrap(tmr0_wrap), .base_wrap(base_wrap),
        .port_pins(port_pins), .push_pc(push_pc), .vec_load(vec_load),
        .vec_sel(vec_sel), .wake_halt(wake_halt), .wake_stop(wake_stop)
    );

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        reg_we = 1'b0; retire = 1'b0; enable_wr = 1'b0;
        tmr0_wrap = 1'b0; base_wrap = 1'b0;
    endtask

    task automatic wr(input logic sel, input logic [3:0] d);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        step();
    endtask

    task automatic rd(input logic sel, input int exp, input string req, input string what);
        reg_sel = sel;
        #1;
        chk(req, int'(reg_rdata), exp, what);
    endtask

    task automatic clear_all();
        wr(1'b0, 4'h0);
        wr(1'b1, 4'h0);
    endtask

    task automatic t_reset();
        rd(1'b0, 0, "R1", "enable after reset");
        rd(1'b1, 0, "R1", "request after reset");
        chk("R1", int'({push_pc, vec_load, vec_sel, wake_halt, wake_stop}), 0, "outputs after reset");
    endtask

    task automatic t_regmap();
        wr(1'b0, 4'hF);
        rd(1'b0, 7, "R2", "enable bit3 dropped");
        wr(1'b1, 4'h5);
        rd(1'b1, 5, "R2", "request readback");
        clear_all();
    endtask

    task automatic t_timers();
        tmr0_wrap = 1'b1; step();
        rd(1'b1, 4, "R3", "timer0 wrap sets bit2");
        reg_we = 1'b1; reg_sel = 1'b1; reg_wdata = 4'h0; base_wrap = 1'b1; step();
        rd(1'b1, 2, "R3", "hw set beats sw clear");
        step();
        rd(1'b1, 2, "R3", "request sticky");
        clear_all();
    endtask

    task automatic t_port();
        port_pins = 4'b1101; step();
        rd(1'b1, 1, "R4", "falling pin sets bit0");
        wr(1'b1, 4'h0);
        port_pins = 4'b0101; step(); step();
        rd(1'b1, 0, "R4", "no request while not all high");
        port_pins = 4'b1111; step();
        port_pins = 4'b1110; step();
        rd(1'b1, 1, "R4", "request after rearm");
        port_pins = 4'b1111;
        clear_all();
    endtask

    task automatic t_direct();
        wr(1'b0, 4'h7);
        retire = 1'b1; step();
        chk("R5", int'(push_pc), 0, "no push without request");
        tmr0_wrap = 1'b1; base_wrap = 1'b1; step();
        retire = 1'b1; step();
        chk("R5", int'(push_pc), 1, "push after retire");
        chk("R7", int'(vec_sel), 0, "sel idle during push");
        step();
        chk("R7", int'({push_pc, vec_load}), 1, "load follows push");
        chk("R6", int'(vec_sel), 1, "timer0 wins");
        rd(1'b0, 0, "R8", "enables cleared");
        rd(1'b1, 6, "R8", "requests kept");
        step();
        chk("R7", int'({push_pc, vec_load, vec_sel}), 0, "pulses end");
        clear_all();
    endtask

    task automatic t_prio(input logic [3:0] en, input logic [3:0] rq, input int exp);
        wr(1'b1, rq);
        wr(1'b0, en);
        retire = 1'b1; step();
        chk("R5", int'(push_pc), 1, "push");
        step();
        chk("R6", int'(vec_sel), exp, "vector code");
        step();
        clear_all();
    endtask

    task automatic t_delay();
        wr(1'b1, 4'h1);
        reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = 4'h1; retire = 1'b1; enable_wr = 1'b1; step();
        chk("R9", int'(push_pc), 0, "no push after N");
        retire = 1'b1; step();
        chk("R9", int'(push_pc), 0, "no push after I1");
        retire = 1'b1; step();
        chk("R9", int'(push_pc), 1, "push after I2");
        step();
        chk("R9", int'(vec_sel), 3, "port vector");
        step();
        clear_all();
    endtask

    task automatic t_cancel(input bit at_i2);
        wr(1'b1, 4'h2);
        reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = 4'h2; retire = 1'b1; enable_wr = 1'b1; step();
        if (at_i2) begin
            retire = 1'b1; step();
            reg_we = 1'b1; reg_sel = 1'b1; reg_wdata = 4'h0; retire = 1'b1; step();
        end else begin
            reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = 4'h0; retire = 1'b1; step();
            retire = 1'b1; step();
        end
        chk("R10", int'(push_pc), 0, at_i2 ? "cancel by I2" : "cancel by I1");
        step();
        chk("R10", int'(vec_load), 0, "no vector after cancel");
        clear_all();
    endtask

    task automatic t_wake();
        wr(1'b1, 4'h4);
        chk("R11", int'({wake_halt, wake_stop}), 2, "timer wakes halt only");
        wr(1'b1, 4'h1);
        chk("R11", int'({wake_halt, wake_stop}), 3, "port wakes both");
        clear_all();
        chk("R11", int'({wake_halt, wake_stop}), 0, "no wake");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset();
        t_regmap();
        t_timers();
        t_port();
        t_direct();
        t_prio(4'h3, 4'h3, 2);
        t_prio(4'h1, 4'h7, 3);
        t_delay();
        t_cancel(1'b0);
        t_cancel(1'b1);
        t_wake();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule